// File: doc/BRIEF.md
# I2C Slave Receiver with Host-Decided Acknowledge

This block is the receive side of an I2C slave that uses 7-bit addressing. It oversamples the SCL and SDA lines with the system clock and finds start and stop conditions. It shifts in the address byte and then the data bytes, most significant bit first. When the address is its own and the direction bit asks for a write, it acknowledges by pulling SDA low in the ninth clock. Each accepted byte lands in a one-entry receive buffer that the host reads. Status flags report the buffer state, overflow, the last bus condition, the acknowledge phase and a pending interrupt.

The host can ask the block to stretch SCL, which means holding the clock line low. With plain stretching, SCL is held after every acknowledged byte until the host releases it. With the address hold or data hold modes, the block pauses right after the eighth falling edge. The host then chooses ACK or NACK through the acknowledge-value input and pulses the release input, and the block drives that choice in the ninth bit. A byte that arrives while the buffer is still unread, or while overflow is pending, is refused with a NACK. After such a refusal, the slave ignores the bus until the next start.

Top module: `i2cs_rx_hold`

## Requirements
- R1: After reset, both line drivers are released. All status flags (buf_full, ovf, start_seen, stop_seen, ack_time, rw_flag, irq) read 0, and rx_byte is 0.
- R2: A start condition (SDA falls while SCL is high) sets start_seen and clears stop_seen. It sets irq only when start_irq_en is 1.
- R3: An address byte whose upper seven bits equal own_addr and whose last bit (R/W) is 0 is acknowledged: SDA is held low during the ninth SCL high phase. The byte is stored in rx_byte, buf_full is set and rw_flag reads 0.
- R4: An address byte with other upper bits, or with R/W = 1, gets no acknowledge, does not touch the buffer and raises no irq. When the upper bits match and R/W = 1, rw_flag reads 1.
- R5: Data bytes that follow an acknowledged address are taken MSB first, stored in rx_byte and acknowledged.
- R6: irq is set after the ninth falling SCL edge of every acknowledged byte, and not after a NACK. Once set, it stays set until clr_irq is pulsed.
- R7: A byte that completes while buf_full is set (and not being read) or while ovf is set is answered with NACK. That byte sets ovf and leaves rx_byte unchanged. Later bytes are ignored until a new start. ovf clears only on clr_ovf.
- R8: A rd_buf pulse clears buf_full. If a byte completes in the very cycle of the rd_buf pulse, it is accepted: no overflow, rx_byte takes the new byte, and buf_full stays 1.
- R9: With stretch_en = 1, SCL is held low from the ninth falling edge of each acknowledged byte until a clk_release pulse.
- R10: With addr_hold_en (address byte) or data_hold_en (data byte) set, the following happens after the eighth falling edge: SCL is held low, irq is set and ack_time reads 1. After clk_release, the ninth bit carries ack_value (0 = ACK, 1 = NACK), unless overflow forces a NACK.
- R11: ack_time is set when a byte completes at the eighth falling edge and cleared at the ninth falling edge.
- R12: A stop condition (SDA rises while SCL is high) sets stop_seen, clears start_seen and returns the slave to idle, where bytes are not acknowledged. It sets irq only when stop_irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL bus line |
| sda_i | input | 1 | Sampled SDA bus line |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr | input | DATA_W-1 | Slave address |
| stretch_en | input | 1 | Hold SCL after each acknowledged byte |
| addr_hold_en | input | 1 | Pause after the eighth edge of the address byte |
| data_hold_en | input | 1 | Pause after the eighth edge of data bytes |
| start_irq_en | input | 1 | Start condition raises irq |
| stop_irq_en | input | 1 | Stop condition raises irq |
| ack_value | input | 1 | Host acknowledge choice in hold modes, 0 = ACK |
| clk_release | input | 1 | Pulse: release a held SCL |
| rd_buf | input | 1 | Pulse: host has read rx_byte |
| clr_irq | input | 1 | Pulse: clear irq |
| clr_ovf | input | 1 | Pulse: clear ovf |
| rx_byte | output | DATA_W | Receive buffer |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | Sticky overflow flag |
| start_seen | output | 1 | Last bus condition was a start |
| stop_seen | output | 1 | Last bus condition was a stop |
| ack_time | output | 1 | 1 between the eighth and ninth falling edges |
| rw_flag | output | 1 | R/W bit of the last matching address |
| irq | output | 1 | Sticky interrupt flag |

## Verification
A byte can complete at the eighth falling edge in the same system-clock cycle as the host's buffer read. The overflow decision then has to treat the buffer as free. The bench provokes this case by counting the two synchroniser stages and the edge register, then placing a one-cycle rd_buf pulse on exactly the cycle in which the falling edge is acted on. With the buffer still full from the address byte, it expects an ACK on the bus, ovf still 0, the new byte in rx_byte and buf_full still 1. Any other outcome shows that the read and the load were ordered wrongly.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_HOLD8,
    ST_ACK,
    ST_HOLD9,
    ST_SKIP
  } rx_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  // Idle bus lines are high, so the chain resets to ones (no false edge).
  always_ff @(posedge clk) begin
    if (rst) begin
      stg  <= '1;
      prev <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign cur = stg[STAGES-1];
endmodule

// File: rtl/i2cs_rx_fsm.sv
module i2cs_rx_fsm
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              accept,
  input  logic              addr_hold_en,
  input  logic              data_hold_en,
  input  logic              stretch_en,
  input  logic              ack_value,
  input  logic              release_i,
  output logic              scl_low,
  output logic              sda_low,
  output logic              ev_byte,
  output logic              ev_hold8,
  output logic              ev_ack9,
  output logic              ev_acked,
  output logic              ev_addr,
  output logic              addr_rw,
  output logic [DATA_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  rx_state_t          state;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  shreg;
  logic               is_addr;
  logic               nack_q;

  logic bus_quiet, byte_end, addr_match, take, hold_sel, ack_end;

  assign bus_quiet  = !start_ev && !stop_ev;
  assign byte_end   = (state == ST_RECV) && scl_fall && (cnt == LAST_BIT) && bus_quiet;
  assign addr_match = (shreg[DATA_W-1:1] == own_addr);
  assign take       = byte_end && (!is_addr || (addr_match && !shreg[0]));
  assign hold_sel   = is_addr ? addr_hold_en : data_hold_en;
  assign ack_end    = (state == ST_ACK) && scl_fall && bus_quiet;

  assign ev_byte  = take;
  assign ev_hold8 = take && hold_sel;
  assign ev_ack9  = ack_end;
  assign ev_acked = ack_end && !nack_q;
  assign ev_addr  = byte_end && is_addr && addr_match;
  assign addr_rw  = shreg[0];
  assign byte_val = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      is_addr <= 1'b0;
      nack_q  <= 1'b0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else if (start_ev) begin
      state   <= ST_RECV;
      cnt     <= '0;
      is_addr <= 1'b1;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else if (stop_ev) begin
      state   <= ST_IDLE;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      case (state)
        ST_RECV: begin
          if (scl_rise && cnt != LAST_BIT) begin
            shreg <= {shreg[DATA_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_end) begin
            if (!take) begin
              state <= ST_SKIP;
            end else if (hold_sel) begin
              state   <= ST_HOLD8;
              scl_low <= 1'b1;
              nack_q  <= !accept;
            end else begin
              state   <= ST_ACK;
              nack_q  <= !accept;
              sda_low <= accept;
            end
          end
        end
        ST_HOLD8: begin
          if (release_i) begin
            state   <= ST_ACK;
            scl_low <= 1'b0;
            nack_q  <= nack_q | ack_value;
            sda_low <= !(nack_q | ack_value);
          end
        end
        ST_ACK: begin
          if (ack_end) begin
            sda_low <= 1'b0;
            if (!nack_q) begin
              cnt     <= '0;
              is_addr <= 1'b0;
              if (stretch_en) begin
                state   <= ST_HOLD9;
                scl_low <= 1'b1;
              end else begin
                state <= ST_RECV;
              end
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_HOLD9: begin
          if (release_i) begin
            state   <= ST_RECV;
            scl_low <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cs_rx_status.sv
module i2cs_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              start_irq_en,
  input  logic              stop_irq_en,
  input  logic              ev_byte,
  input  logic [DATA_W-1:0] byte_val,
  input  logic              ev_hold8,
  input  logic              ev_ack9,
  input  logic              ev_acked,
  input  logic              ev_addr,
  input  logic              addr_rw,
  input  logic              rd_buf,
  input  logic              clr_irq,
  input  logic              clr_ovf,
  output logic              accept,
  output logic [DATA_W-1:0] rx_byte,
  output logic              buf_full,
  output logic              ovf,
  output logic              start_seen,
  output logic              stop_seen,
  output logic              ack_time,
  output logic              rw_flag,
  output logic              irq
);
  logic irq_set;

  // A read in the same cycle frees the slot for the incoming byte.
  assign accept  = !ovf && (!buf_full || rd_buf);
  assign irq_set = (start_ev && start_irq_en) || (stop_ev && stop_irq_en)
                 || ev_hold8 || ev_acked;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte    <= '0;
      buf_full   <= 1'b0;
      ovf        <= 1'b0;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      ack_time   <= 1'b0;
      rw_flag    <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (ev_byte && accept) begin
        rx_byte  <= byte_val;
        buf_full <= 1'b1;
      end else if (rd_buf) begin
        buf_full <= 1'b0;
      end

      if (ev_byte && !accept) ovf <= 1'b1;
      else if (clr_ovf)       ovf <= 1'b0;

      if (start_ev) begin
        start_seen <= 1'b1;
        stop_seen  <= 1'b0;
      end else if (stop_ev) begin
        start_seen <= 1'b0;
        stop_seen  <= 1'b1;
      end

      if (start_ev || stop_ev || ev_ack9) ack_time <= 1'b0;
      else if (ev_byte)                   ack_time <= 1'b1;

      if (ev_addr) rw_flag <= addr_rw;

      if (irq_set)      irq <= 1'b1;
      else if (clr_irq) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cs_rx_hold.sv
module i2cs_rx_hold #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              stretch_en,
  input  logic              addr_hold_en,
  input  logic              data_hold_en,
  input  logic              start_irq_en,
  input  logic              stop_irq_en,
  input  logic              ack_value,
  input  logic              clk_release,
  input  logic              rd_buf,
  input  logic              clr_irq,
  input  logic              clr_ovf,
  output logic [DATA_W-1:0] rx_byte,
  output logic              buf_full,
  output logic              ovf,
  output logic              start_seen,
  output logic              stop_seen,
  output logic              ack_time,
  output logic              rw_flag,
  output logic              irq
);
  localparam int LINES = 2;

  logic [LINES-1:0] ln_cur, ln_prev;
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic accept, ev_byte, ev_hold8, ev_ack9, ev_acked, ev_addr, addr_rw;
  logic [DATA_W-1:0] byte_val;

  i2cs_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  ({sda_i, scl_i}),
    .cur  (ln_cur),
    .prev (ln_prev)
  );

  assign scl_s    = ln_cur[0];
  assign sda_s    = ln_cur[1];
  assign scl_p    = ln_prev[0];
  assign sda_p    = ln_prev[1];
  assign scl_rise = scl_s && !scl_p;
  assign scl_fall = !scl_s && scl_p;
  assign start_ev = scl_s && scl_p && sda_p && !sda_s;
  assign stop_ev  = scl_s && scl_p && !sda_p && sda_s;

  i2cs_rx_fsm #(.DATA_W(DATA_W)) fsm_i (
    .clk          (clk),
    .rst          (rst),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .sda_s        (sda_s),
    .start_ev     (start_ev),
    .stop_ev      (stop_ev),
    .own_addr     (own_addr),
    .accept       (accept),
    .addr_hold_en (addr_hold_en),
    .data_hold_en (data_hold_en),
    .stretch_en   (stretch_en),
    .ack_value    (ack_value),
    .release_i    (clk_release),
    .scl_low      (scl_drive_low),
    .sda_low      (sda_drive_low),
    .ev_byte      (ev_byte),
    .ev_hold8     (ev_hold8),
    .ev_ack9      (ev_ack9),
    .ev_acked     (ev_acked),
    .ev_addr      (ev_addr),
    .addr_rw      (addr_rw),
    .byte_val     (byte_val)
  );

  i2cs_rx_status #(.DATA_W(DATA_W)) stat_i (
    .clk          (clk),
    .rst          (rst),
    .start_ev     (start_ev),
    .stop_ev      (stop_ev),
    .start_irq_en (start_irq_en),
    .stop_irq_en  (stop_irq_en),
    .ev_byte      (ev_byte),
    .byte_val     (byte_val),
    .ev_hold8     (ev_hold8),
    .ev_ack9      (ev_ack9),
    .ev_acked     (ev_acked),
    .ev_addr      (ev_addr),
    .addr_rw      (addr_rw),
    .rd_buf       (rd_buf),
    .clr_irq      (clr_irq),
    .clr_ovf      (clr_ovf),
    .accept       (accept),
    .rx_byte      (rx_byte),
    .buf_full     (buf_full),
    .ovf          (ovf),
    .start_seen   (start_seen),
    .stop_seen    (stop_seen),
    .ack_time     (ack_time),
    .rw_flag      (rw_flag),
    .irq          (irq)
  );
endmodule

// File: rtl/i2cs_rx_hold_chk.sv
module i2cs_rx_hold_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_drive_low,
  input logic              sda_drive_low,
  input logic              irq,
  input logic              clr_irq,
  input logic              buf_full,
  input logic              ovf,
  input logic [DATA_W-1:0] rx_byte,
  input logic              start_seen,
  input logic              stop_seen
);
  logic rst_q = 1'b0;

  always @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      AST_RESET_IDLE: assert (!scl_drive_low && !sda_drive_low && !irq && !buf_full && !ovf); // R1
    end
  end

  AST_COND_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(start_seen && stop_seen)); // R12

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_irq) |=> irq); // R6

  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_byte) |-> buf_full); // R3

  AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $stable(rx_byte)); // R7

  AST_STRETCH_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low) |-> irq); // R10

  AST_LINES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(scl_drive_low && sda_drive_low)); // R9
endmodule

bind i2cs_rx_hold i2cs_rx_hold_chk #(.DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .irq           (irq),
  .clr_irq       (clr_irq),
  .buf_full      (buf_full),
  .ovf           (ovf),
  .rx_byte       (rx_byte),
  .start_seen    (start_seen),
  .stop_seen     (stop_seen)
);

// File: tb/i2cs_rx_hold_tb_top.sv
module i2cs_rx_hold_tb_top;
  localparam int CLK_P = 10;
  localparam int H = 6;
  localparam logic [6:0] OWN = 7'h2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_dl, sda_dl, scl_line, sda_line;
  assign scl_line = scl_m & ~scl_dl;
  assign sda_line = sda_m & ~sda_dl;

  logic stretch_en = 0, ah_en = 0, dh_en = 0, sie = 0, pie = 0, ack_val = 0;
  logic rel = 0, rd = 0, cirq = 0, covf = 0;
  logic [7:0] rx_byte;
  logic buf_full, ovf, start_seen, stop_seen, ack_time, rw_flag, irq;

  i2cs_rx_hold dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .own_addr(OWN),
    .stretch_en(stretch_en), .addr_hold_en(ah_en), .data_hold_en(dh_en),
    .start_irq_en(sie), .stop_irq_en(pie), .ack_value(ack_val),
    .clk_release(rel), .rd_buf(rd), .clr_irq(cirq), .clr_ovf(covf),
    .rx_byte(rx_byte), .buf_full(buf_full), .ovf(ovf),
    .start_seen(start_seen), .stop_seen(stop_seen), .ack_time(ack_time),
    .rw_flag(rw_flag), .irq(irq)
  );

  int total = 0, bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    wt(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(H);
    scl_up();
    scl_m = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // Last bit: rd pulse lands on the cycle the 8th falling edge is acted on.
  task automatic send_byte_rd(input logic [7:0] v);
    for (int i = 7; i >= 1; i--) send_bit(v[i]);
    sda_m = v[0]; wt(H);
    scl_up();
    scl_m = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    wt(H);
  endtask

  task automatic ack_clock(output logic acked);
    sda_m = 1'b1; wt(H);
    scl_up();
    acked = !sda_line;
    scl_m = 1'b0; wt(H);
  endtask

  task automatic do_start();
    sda_m = 1'b1; scl_up();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wt(H);
    scl_up();
    sda_m = 1'b1; wt(H);
  endtask

  task automatic pulse_rd();   rd = 1;   @(negedge clk); rd = 0;   wt(1); endtask
  task automatic pulse_cirq(); cirq = 1; @(negedge clk); cirq = 0; wt(1); endtask
  task automatic pulse_covf(); covf = 1; @(negedge clk); covf = 0; wt(1); endtask
  task automatic pulse_rel();  rel = 1;  @(negedge clk); rel = 0;  wt(1); endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic ak;
    logic [7:0] v;
    wt(4);
    rst = 1'b0;
    wt(2);
    // R1 reset state
    check("R1 scl drive", scl_dl, 0);
    check("R1 sda drive", sda_dl, 0);
    check("R1 flags", {buf_full, ovf, start_seen, stop_seen, ack_time, rw_flag, irq}, 0);
    check("R1 rx_byte", rx_byte, 0);

    // R2 start with interrupt enabled, R12 stop without
    sie = 1;
    do_start();
    check("R2 start_seen", start_seen, 1);
    check("R2 stop_seen cleared", stop_seen, 0);
    check("R2 irq on start", irq, 1);
    pulse_cirq();
    check("R6 irq cleared", irq, 0);
    do_stop();
    check("R12 stop_seen", stop_seen, 1);
    check("R12 start_seen cleared", start_seen, 0);
    check("R12 no irq when disabled", irq, 0);
    sie = 0;
    do_start();
    check("R2 no irq when disabled", irq, 0);
    do_stop();

    // R3/R4 address sweep
    for (int a = 0; a < 128; a++) begin
      do_start();
      send_byte({a[6:0], 1'b0});
      ack_clock(ak);
      if (a[6:0] == OWN) begin
        check("R3 ack own addr", ak, 1);
        check("R3 buffer holds addr", rx_byte, {OWN, 1'b0});
        check("R3 buf_full", buf_full, 1);
        check("R3 rw_flag", rw_flag, 0);
        check("R6 irq after ack", irq, 1);
      end else begin
        check("R4 no ack", ak, 0);
        check("R4 no load", buf_full, 0);
        check("R4 no irq", irq, 0);
      end
      do_stop();
      pulse_rd();
      pulse_cirq();
    end

    // R4 read direction on own address
    do_start();
    send_byte({OWN, 1'b1});
    ack_clock(ak);
    check("R4 rw=1 no ack", ak, 0);
    check("R4 rw_flag set", rw_flag, 1);
    check("R4 rw=1 no load", buf_full, 0);
    do_stop();

    // R5/R6 data stream
    do_start();
    send_byte({OWN, 1'b0});
    ack_clock(ak);
    pulse_rd(); pulse_cirq();
    check("R8 read clears full", buf_full, 0);
    for (int i = 0; i < 6; i++) begin
      v = 8'((i * 53 + 17) & 255);
      send_byte(v);
      ack_clock(ak);
      check("R5 data ack", ak, 1);
      check("R5 data byte", rx_byte, v);
      check("R6 irq per byte", irq, 1);
      check("R11 ack_time after 9th", ack_time, 0);
      pulse_rd(); pulse_cirq();
    end
    do_stop();

    // R7 overflow
    do_start();
    send_byte({OWN, 1'b0});
    ack_clock(ak);
    pulse_cirq();
    send_byte(8'hC3);
    ack_clock(ak);
    check("R7 nack when full", ak, 0);
    check("R7 ovf set", ovf, 1);
    check("R7 buffer kept", rx_byte, {OWN, 1'b0});
    check("R6 no irq after nack", irq, 0);
    send_byte(8'h11);
    ack_clock(ak);
    check("R7 later byte ignored", ak, 0);
    do_stop();
    pulse_rd();
    check("R8 read clears full", buf_full, 0);
    check("R7 ovf sticky", ovf, 1);
    do_start();
    send_byte({OWN, 1'b0});
    ack_clock(ak);
    check("R7 nack while ovf", ak, 0);
    check("R7 no load while ovf", buf_full, 0);
    do_stop();
    pulse_covf();
    check("R7 ovf cleared", ovf, 0);
    pulse_cirq();

    // R8 read coinciding with byte completion
    do_start();
    send_byte({OWN, 1'b0});
    ack_clock(ak);
    send_byte_rd(8'h96);
    ack_clock(ak);
    check("R8 same-cycle ack", ak, 1);
    check("R8 same-cycle no ovf", ovf, 0);
    check("R8 same-cycle byte", rx_byte, 8'h96);
    check("R8 same-cycle full", buf_full, 1);
    do_stop();
    pulse_rd(); pulse_cirq();

    // R9 stretching after ninth edge
    stretch_en = 1;
    do_start();
    send_byte({OWN, 1'b0});
    ack_clock(ak);
    check("R9 held after addr", scl_dl, 1);
    wt(20);
    check("R9 still held", scl_dl, 1);
    pulse_rd(); pulse_cirq();
    pulse_rel();
    check("R9 released", scl_dl, 0);
    send_byte(8'hA7);
    ack_clock(ak);
    check("R9 data ack", ak, 1);
    check("R9 held after data", scl_dl, 1);
    check("R5 stretched data byte", rx_byte, 8'hA7);
    pulse_rel();
    do_stop();
    stretch_en = 0;
    pulse_rd(); pulse_cirq();

    // R10/R11 hold modes
    ah_en = 1; dh_en = 1;
    do_start();
    send_byte({OWN, 1'b0});
    check("R10 held at 8th edge", scl_dl, 1);
    check("R10 irq at 8th edge", irq, 1);
    check("R11 ack_time set", ack_time, 1);
    check("R10 sda free while held", sda_dl, 0);
    wt(20);
    check("R10 still held", scl_dl, 1);
    pulse_cirq();
    ack_val = 0;
    pulse_rel();
    ack_clock(ak);
    check("R10 host ack", ak, 1);
    check("R11 ack_time cleared", ack_time, 0);
    check("R6 irq after host ack", irq, 1);
    pulse_rd(); pulse_cirq();
    send_byte(8'h5E);
    check("R10 data held", scl_dl, 1);
    check("R5 held data byte", rx_byte, 8'h5E);
    check("R11 data ack_time", ack_time, 1);
    pulse_cirq();
    ack_val = 1;
    pulse_rel();
    ack_clock(ak);
    check("R10 host nack", ak, 0);
    check("R6 no irq after host nack", irq, 0);
    check("R11 ack_time cleared nack", ack_time, 0);
    do_stop();
    ack_val = 0; ah_en = 0; dh_en = 0;
    pulse_rd();

    // R12 stop interrupt and idle after stop
    pie = 1;
    do_start();
    do_stop();
    check("R12 irq on stop", irq, 1);
    check("R12 stop_seen", stop_seen, 1);
    pulse_cirq();
    pie = 0;
    scl_m = 0; wt(H);
    send_byte({OWN, 1'b0});
    ack_clock(ak);
    check("R12 idle ignores byte", ak, 0);
    check("R12 idle no load", buf_full, 0);
    do_stop();

    finish_run();
  end
endmodule